// File: doc/BRIEF.md
# Interrupt Controller Host Command Port

This block is the host-facing register port of an eight-line interrupt controller. A processor reaches it through a one-bit address with single-cycle write and read strobes. Writes at address 0 either restart the controller (a byte with bit 4 set) or carry run-time commands. Writes at address 1 load the mask or supply the extra setup bytes that follow a restart. The port owns the in-service register, the mask, the rotation base, the vector base and the mode flags. It carries out end-of-interrupt, rotation and poll commands and answers register reads.

The pending register and the request arbitration sit outside the block. The port reads the pending bits on `pend_i` and clears them through single-cycle pulses on `pend_clr_o`. An external resolver supplies the winning request line on `res_valid_i`/`res_line_i`, and the acknowledge logic reports each accepted line on `ack_en_i`/`ack_line_i`.

The setup sequencer has four named states, encoded on `init_step_o`:
- READY (0): normal operation.
- BASE (1): waiting for the vector-base byte.
- CASCADE (2): waiting for the cascade byte.
- MODE (3): waiting for the mode byte.

Its transitions are:
- restart: any state goes to BASE.
- base-done: BASE goes to CASCADE in cascade mode, to MODE in single mode with word 4 requested, and to READY otherwise.
- cascade-done: CASCADE goes to MODE if word 4 was requested, else to READY.
- mode-done: MODE goes to READY.

Top module: `pic_host_port`

## Requirements
- R1: An address-0 write with bit 4 set has these effects:
  - It clears the in-service register, mask, rotation base, vector base, read select, poll, special-mask, auto-EOI, rotate-on-auto-EOI and nested-mode state.
  - It pulses `pend_clr_o` all ones for one cycle.
  - It enters BASE.
  - It latches bit 1 as single mode and bit 0 as word-4-needed.
- R2: In BASE, an address-1 write sets the vector base to the byte with its low 3 bits zeroed. The next state is CASCADE if single mode is clear, MODE if single mode and word-4-needed are both set, and READY otherwise.
- R3: In CASCADE, an address-1 write goes to MODE if word-4-needed is set, else to READY. In MODE, an address-1 write sets nested mode from bit 4 and auto-EOI from bit 1, then goes to READY.
- R4: In READY, an address-1 write loads the mask. A read of address 1 without a poll armed returns the mask in every setup state.
- R5: An address-0 write with bit 4 clear and bit 3 set is a select command:
  - Bit 2 arms a poll.
  - If bit 1 is set, bit 0 picks the read source at address 0 (1 = in-service register, 0 = `pend_i`).
  - If bit 6 is set, bit 5 becomes the special-mask flag.
- R6: An address-0 write with bits 4 and 3 clear is a command; bits 7:5 hold its code. Codes 1 and 5 clear the in-service bit of highest priority. Priority runs from the rotation base upward, modulo 8. Code 5 also sets the base to that line plus 1. With no in-service bit set, neither code changes anything.
- R7: Code 3 clears the in-service bit named by bits 2:0. Code 7 does the same and also sets the base to that line plus 1. Code 6 only sets the base to line plus 1.
- R8: Code 0 clears and code 4 sets rotate-on-auto-EOI. Code 2 changes nothing.
- R9: A read while a poll is armed has these effects, whatever the address:
  - It returns the resolver line, or 7 when `res_valid_i` is low.
  - With a valid line, it clears that line's in-service bit and pulses that line's bit on `pend_clr_o`.
  - It disarms the poll.
- R10: On acknowledge with auto-EOI clear, the line's in-service bit is set. With auto-EOI set, the in-service register is left unchanged, and the base becomes line plus 1 only if rotate-on-auto-EOI is set.
- R11: `rdata_o` is registered. It takes its new value at the clock edge that samples `rd_en_i` and holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe, one cycle |
| rd_en_i | input | 1 | Host read strobe, one cycle |
| addr_i | input | 1 | Host register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Registered read data |
| pend_i | input | 8 | Pending request bits from outside |
| res_valid_i | input | 1 | Resolver has a winning request |
| res_line_i | input | 3 | Resolver winning line |
| ack_en_i | input | 1 | Acknowledge strobe |
| ack_line_i | input | 3 | Acknowledged line |
| pend_clr_o | output | 8 | One-cycle pending clear pulses |
| isr_o | output | 8 | In-service register |
| imr_o | output | 8 | Mask register |
| prio_base_o | output | 3 | Rotation base (highest-priority line) |
| vec_base_o | output | 8 | Vector base |
| spec_mask_o | output | 1 | Special-mask flag |
| nested_o | output | 1 | Special nested mode flag |
| auto_eoi_o | output | 1 | Auto-EOI flag |
| init_step_o | output | 2 | Setup sequencer state |

## Verification
Every register and flag output changes at the clock edge that samples a write or acknowledge strobe. The bench therefore drives each strobe for one cycle starting at a falling edge and checks the outputs at the next falling edge. Read data and the `pend_clr_o` pulse appear at that same edge and last exactly one cycle, so they are sampled at the falling edge right after the strobe and no later. A restart's all-ones clear pulse is checked in the same way, right after its write.

// File: rtl/pic_port_pkg.sv
package pic_port_pkg;

    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_BASE    = 2'd1,
        ST_CASCADE = 2'd2,
        ST_MODE    = 2'd3
    } init_st_e;

    typedef enum logic [2:0] {
        OP_ROT_OFF      = 3'd0,
        OP_EOI          = 3'd1,
        OP_NOP          = 3'd2,
        OP_EOI_LINE     = 3'd3,
        OP_ROT_ON       = 3'd4,
        OP_EOI_ROT      = 3'd5,
        OP_SET_BASE     = 3'd6,
        OP_EOI_LINE_ROT = 3'd7
    } op_e;

endpackage

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
    import pic_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart_i,
    input  logic     single_i,
    input  logic     need4_i,
    input  logic     wr1_i,
    output init_st_e state_o,
    output logic     load_mask_o,
    output logic     load_base_o,
    output logic     load_mode_o
);

    init_st_e state_q, state_n;
    logic     single_q, need4_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            single_q <= 1'b0;
            need4_q  <= 1'b0;
        end else if (restart_i) begin
            single_q <= single_i;
            need4_q  <= need4_i;
        end
    end

    always_comb begin
        state_n     = state_q;
        load_mask_o = 1'b0;
        load_base_o = 1'b0;
        load_mode_o = 1'b0;
        if (restart_i) begin
            state_n = ST_BASE;
        end else if (wr1_i) begin
            unique case (state_q)
                ST_READY: load_mask_o = 1'b1;
                ST_BASE: begin
                    load_base_o = 1'b1;
                    if (!single_q)    state_n = ST_CASCADE;
                    else if (need4_q) state_n = ST_MODE;
                    else              state_n = ST_READY;
                end
                ST_CASCADE: state_n = need4_q ? ST_MODE : ST_READY;
                ST_MODE: begin
                    load_mode_o = 1'b1;
                    state_n     = ST_READY;
                end
            endcase
        end
    end

    assign state_o = state_q;

    // R3
    mode_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MODE && wr1_i && !restart_i) |=> (state_q == ST_READY));

    // R1
    restart_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (state_q == ST_BASE));

endmodule

// File: rtl/pic_isr_pick.sv
module pic_isr_pick #(
    parameter int N_LINES = 8,
    localparam int LW = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] vec_i,
    input  logic [LW-1:0]      base_i,
    output logic               found_o,
    output logic [LW-1:0]      line_o
);

    logic [LW-1:0]      idx [N_LINES];
    logic [N_LINES-1:0] hit;

    for (genvar k = 0; k < N_LINES; k++) begin : g_slot
        assign idx[k] = base_i + LW'(k);
        assign hit[k] = vec_i[idx[k]];
    end

    always_comb begin
        line_o = '0;
        for (int k = N_LINES - 1; k >= 0; k--) begin
            if (hit[k]) line_o = idx[k];
        end
    end

    assign found_o = |vec_i;

    // R6
    always_comb begin
        isr_pick_chk: assert (!found_o || vec_i[line_o]);
    end

endmodule

// File: rtl/pic_host_port.sv
module pic_host_port
    import pic_port_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int LW = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic               addr_i,
    input  logic [7:0]         wdata_i,
    output logic [7:0]         rdata_o,
    input  logic [N_LINES-1:0] pend_i,
    input  logic               res_valid_i,
    input  logic [LW-1:0]      res_line_i,
    input  logic               ack_en_i,
    input  logic [LW-1:0]      ack_line_i,
    output logic [N_LINES-1:0] pend_clr_o,
    output logic [N_LINES-1:0] isr_o,
    output logic [N_LINES-1:0] imr_o,
    output logic [LW-1:0]      prio_base_o,
    output logic [7:0]         vec_base_o,
    output logic               spec_mask_o,
    output logic               nested_o,
    output logic               auto_eoi_o,
    output logic [1:0]         init_step_o
);

    // Host write decode
    logic wr0, wr1, restart, sel_cmd, op_cmd, poll_rd;
    op_e  op;
    logic [LW-1:0] op_line, poll_line;

    assign wr0       = wr_en_i & ~addr_i;
    assign wr1       = wr_en_i & addr_i;
    assign restart   = wr0 & wdata_i[4];
    assign sel_cmd   = wr0 & ~wdata_i[4] & wdata_i[3];
    assign op_cmd    = wr0 & ~wdata_i[4] & ~wdata_i[3];
    assign op        = op_e'(wdata_i[7:5]);
    assign op_line   = wdata_i[LW-1:0];

    // State registers and their next values
    logic [N_LINES-1:0] isr_q, isr_n, imr_q, imr_n, pclr_q, pclr_n;
    logic [LW-1:0]      base_q, base_n;
    logic [7:0]         vbase_q, vbase_n, rdata_q;
    logic rdsel_q, rdsel_n, poll_q, poll_n, smm_q, smm_n;
    logic aeoi_q, aeoi_n, rot_q, rot_n, nest_q, nest_n;

    assign poll_rd   = rd_en_i & poll_q;
    assign poll_line = res_valid_i ? res_line_i : LW'(N_LINES - 1);

    init_st_e step;
    logic     ld_mask, ld_base, ld_mode;

    pic_init_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (restart),
        .single_i    (wdata_i[1]),
        .need4_i     (wdata_i[0]),
        .wr1_i       (wr1),
        .state_o     (step),
        .load_mask_o (ld_mask),
        .load_base_o (ld_base),
        .load_mode_o (ld_mode)
    );

    logic          pk_found;
    logic [LW-1:0] pk_line;

    pic_isr_pick #(.N_LINES(N_LINES)) u_pick (
        .vec_i   (isr_q),
        .base_i  (base_q),
        .found_o (pk_found),
        .line_o  (pk_line)
    );

    always_comb begin
        isr_n   = isr_q;
        imr_n   = imr_q;
        base_n  = base_q;
        vbase_n = vbase_q;
        rdsel_n = rdsel_q;
        poll_n  = poll_q;
        smm_n   = smm_q;
        aeoi_n  = aeoi_q;
        rot_n   = rot_q;
        nest_n  = nest_q;
        pclr_n  = '0;
        if (restart) begin
            isr_n   = '0;
            imr_n   = '0;
            base_n  = '0;
            vbase_n = '0;
            rdsel_n = 1'b0;
            poll_n  = 1'b0;
            smm_n   = 1'b0;
            aeoi_n  = 1'b0;
            rot_n   = 1'b0;
            nest_n  = 1'b0;
            pclr_n  = '1;
        end else begin
            if (ld_mask) imr_n = wdata_i[N_LINES-1:0];
            if (ld_base) vbase_n = {wdata_i[7:LW], LW'(0)};
            if (ld_mode) begin
                nest_n = wdata_i[4];
                aeoi_n = wdata_i[1];
            end
            if (sel_cmd) begin
                if (wdata_i[2]) poll_n  = 1'b1;
                if (wdata_i[1]) rdsel_n = wdata_i[0];
                if (wdata_i[6]) smm_n   = wdata_i[5];
            end
            if (op_cmd) begin
                unique case (op)
                    OP_ROT_OFF, OP_ROT_ON: rot_n = wdata_i[7];
                    OP_EOI, OP_EOI_ROT: begin
                        if (pk_found) begin
                            isr_n[pk_line] = 1'b0;
                            if (op == OP_EOI_ROT) base_n = pk_line + LW'(1);
                        end
                    end
                    OP_EOI_LINE: isr_n[op_line] = 1'b0;
                    OP_SET_BASE: base_n = op_line + LW'(1);
                    OP_EOI_LINE_ROT: begin
                        isr_n[op_line] = 1'b0;
                        base_n         = op_line + LW'(1);
                    end
                    OP_NOP: ;
                endcase
            end
            if (poll_rd) begin
                poll_n = 1'b0;
                if (res_valid_i) begin
                    isr_n[res_line_i]  = 1'b0;
                    pclr_n[res_line_i] = 1'b1;
                end
            end
            if (ack_en_i) begin
                if (aeoi_q) begin
                    if (rot_q) base_n = ack_line_i + LW'(1);
                end else begin
                    isr_n[ack_line_i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q   <= '0;
            imr_q   <= '0;
            base_q  <= '0;
            vbase_q <= '0;
            rdsel_q <= 1'b0;
            poll_q  <= 1'b0;
            smm_q   <= 1'b0;
            aeoi_q  <= 1'b0;
            rot_q   <= 1'b0;
            nest_q  <= 1'b0;
            pclr_q  <= '0;
        end else begin
            isr_q   <= isr_n;
            imr_q   <= imr_n;
            base_q  <= base_n;
            vbase_q <= vbase_n;
            rdsel_q <= rdsel_n;
            poll_q  <= poll_n;
            smm_q   <= smm_n;
            aeoi_q  <= aeoi_n;
            rot_q   <= rot_n;
            nest_q  <= nest_n;
            pclr_q  <= pclr_n;
        end
    end

    // Read path: registered, updated only on a read strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            if (poll_q)       rdata_q <= 8'(poll_line);
            else if (addr_i)  rdata_q <= 8'(imr_q);
            else if (rdsel_q) rdata_q <= 8'(isr_q);
            else              rdata_q <= 8'(pend_i);
        end
    end

    assign rdata_o     = rdata_q;
    assign pend_clr_o  = pclr_q;
    assign isr_o       = isr_q;
    assign imr_o       = imr_q;
    assign prio_base_o = base_q;
    assign vec_base_o  = vbase_q;
    assign spec_mask_o = smm_q;
    assign nested_o    = nest_q;
    assign auto_eoi_o  = aeoi_q;
    assign init_step_o = step;

    // R1
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (isr_o == '0 && imr_o == '0 && pend_clr_o == '1));

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1 && step == ST_READY) |=> (imr_o == $past(wdata_i[N_LINES-1:0])));

    // R9
    poll_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && !restart) |=> !poll_q);

    // R9
    pclr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr_o != '1) |-> $onehot0(pend_clr_o));

    // R10
    ack_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en_i && !aeoi_q && !wr_en_i && !rd_en_i) |=> isr_o[$past(ack_line_i)]);

endmodule

// File: tb/pic_host_port_test.sv
module pic_host_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pend = 8'h5A;
    logic       res_valid = 1'b0;
    logic [2:0] res_line = '0;
    logic       ack_en = 1'b0;
    logic [2:0] ack_line = '0;
    logic [7:0] pend_clr, isr, imr, vec_base;
    logic [2:0] base;
    logic       spec_mask, nested, auto_eoi;
    logic [1:0] step;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pic_host_port uut (
        .clk (clk), .rst_n (rst_n), .wr_en_i (wr_en), .rd_en_i (rd_en),
        .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .pend_i (pend),
        .res_valid_i (res_valid), .res_line_i (res_line),
        .ack_en_i (ack_en), .ack_line_i (ack_line), .pend_clr_o (pend_clr),
        .isr_o (isr), .imr_o (imr), .prio_base_o (base), .vec_base_o (vec_base),
        .spec_mask_o (spec_mask), .nested_o (nested), .auto_eoi_o (auto_eoi),
        .init_step_o (step)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ack(input logic [2:0] l);
        @(negedge clk);
        ack_en = 1'b1; ack_line = l;
        @(negedge clk);
        ack_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "reset isr", isr, 0);
        chk("R1", "reset imr", imr, 0);
        chk("R1", "reset base", base, 0);
        chk("R11", "reset rdata", rdata, 0);
        chk("R2", "reset step", step, 0);
    endtask

    task automatic t_init_paths();
        wr(0, 8'h13);
        chk("R1", "step after restart", step, 1);
        chk("R1", "pend_clr all", pend_clr, 8'hFF);
        wr(1, 8'h47);
        chk("R2", "vector base", vec_base, 8'h40);
        chk("R2", "single+need4 -> MODE", step, 3);
        wr(1, 8'h12);
        chk("R3", "mode -> READY", step, 0);
        chk("R3", "nested set", nested, 1);
        chk("R3", "auto eoi set", auto_eoi, 1);
        wr(0, 8'h10);
        chk("R1", "nested cleared", nested, 0);
        chk("R1", "auto eoi cleared", auto_eoi, 0);
        wr(1, 8'h20);
        chk("R2", "cascade -> CASCADE", step, 2);
        wr(1, 8'h00);
        chk("R3", "cascade no word4 -> READY", step, 0);
        wr(0, 8'h11); wr(1, 8'h08); wr(1, 8'h00);
        chk("R3", "cascade word4 -> MODE", step, 3);
        wr(1, 8'h00);
        chk("R3", "MODE -> READY", step, 0);
        wr(0, 8'h12); wr(1, 8'h88);
        chk("R2", "single no word4 -> READY", step, 0);
        chk("R2", "vector base low bits", vec_base, 8'h88);
    endtask

    task automatic t_mask();
        wr(1, 8'hA5);
        chk("R4", "mask load", imr, 8'hA5);
        rd(1);
        chk("R4", "mask read", rdata, 8'hA5);
        wr(0, 8'h10);
        chk("R1", "mask cleared", imr, 0);
        rd(1);
        chk("R4", "mask read in BASE", rdata, 0);
        wr(1, 8'hA5);
        chk("R4", "base byte not mask", imr, 0);
        wr(1, 8'h00);
        wr(1, 8'hA5);
        chk("R4", "mask reload", imr, 8'hA5);
    endtask

    task automatic t_eoi();
        ack(3); ack(5); ack(1);
        chk("R10", "ack sets isr", isr, 8'h2A);
        wr(0, 8'h20);
        chk("R6", "nonspecific eoi", isr, 8'h28);
        wr(0, 8'hA0);
        chk("R6", "rotating eoi isr", isr, 8'h20);
        chk("R6", "rotating eoi base", base, 4);
        ack(2);
        wr(0, 8'h20);
        chk("R6", "eoi honours base", isr, 8'h04);
        wr(0, 8'h62);
        chk("R7", "specific eoi", isr, 0);
        wr(0, 8'h20);
        chk("R6", "eoi empty isr", isr, 0);
        chk("R6", "eoi empty base", base, 4);
        ack(6);
        wr(0, 8'hE6);
        chk("R7", "specific rotating isr", isr, 0);
        chk("R7", "specific rotating base", base, 7);
        wr(0, 8'hC2);
        chk("R7", "set base", base, 3);
        ack(0);
        wr(0, 8'h40);
        chk("R8", "code 2 isr", isr, 8'h01);
        chk("R8", "code 2 base", base, 3);
        ack(4);
        wr(0, 8'h20);
        chk("R6", "base 3 picks line 4", isr, 8'h01);
    endtask

    task automatic t_select();
        rd(0);
        chk("R5", "pending read", rdata, 8'h5A);
        wr(0, 8'h0B); rd(0);
        chk("R5", "isr read", rdata, 8'h01);
        wr(0, 8'h09); rd(0);
        chk("R5", "select kept", rdata, 8'h01);
        wr(0, 8'h0A); rd(0);
        chk("R5", "pending again", rdata, 8'h5A);
        wr(0, 8'h68);
        chk("R5", "special mask on", spec_mask, 1);
        wr(0, 8'h28);
        chk("R5", "special mask kept", spec_mask, 1);
        wr(0, 8'h48);
        chk("R5", "special mask off", spec_mask, 0);
    endtask

    task automatic t_poll();
        ack(5);
        res_valid = 1'b1; res_line = 3'd5;
        wr(0, 8'h0C); rd(1);
        chk("R9", "poll data", rdata, 8'h05);
        chk("R9", "poll pend clear", pend_clr, 8'h20);
        chk("R9", "poll isr clear", isr, 8'h01);
        rd(1);
        chk("R9", "poll disarmed", rdata, 8'hA5);
        chk("R9", "no pend clear", pend_clr, 0);
        res_valid = 1'b0;
        wr(0, 8'h0C); rd(0);
        chk("R9", "poll no request", rdata, 8'h07);
        chk("R9", "no request isr", isr, 8'h01);
    endtask

    task automatic t_auto_eoi();
        wr(0, 8'h13); wr(1, 8'h00); wr(1, 8'h02);
        ack(3);
        chk("R10", "auto eoi isr", isr, 0);
        chk("R10", "auto eoi no rotate", base, 0);
        wr(0, 8'h80); ack(3);
        chk("R10", "auto eoi rotate", base, 4);
        chk("R8", "rotate isr", isr, 0);
        wr(0, 8'h00); ack(6);
        chk("R8", "rotate off", base, 4);
    endtask

    task automatic t_restart_clear();
        wr(0, 8'h10); wr(1, 8'h00); wr(1, 8'h00);
        ack(7); wr(1, 8'h33); wr(0, 8'h0B); wr(0, 8'hC4);
        chk("R7", "base before restart", base, 5);
        wr(0, 8'h10);
        chk("R1", "restart isr", isr, 0);
        chk("R1", "restart base", base, 0);
        chk("R1", "restart imr", imr, 0);
        rd(0);
        chk("R1", "restart read select", rdata, 8'h5A);
        @(negedge clk);
        chk("R11", "rdata holds", rdata, 8'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init_paths();
        t_mask();
        t_eoi();
        t_select();
        t_poll();
        t_auto_eoi();
        t_restart_clear();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule